// File: doc/BRIEF.md
# Multiplexed Sampling Converter Conversion Sequencer

This block is the digital control side of a multiplexed sampling converter. It turns a fast external clock into a slower internal conversion rate. The rate is set by a two-bit ratio code. When both active-low strobes, chip select and convert, are low, the block opens a conversion. It then holds a busy flag high for a fixed number of internal clocks, followed by a short acquisition window. When busy drops, the conversion result lands in an output register.

The analog side is replaced by a 16-bit stimulus port. The block reports which mux channel is being sampled, and the stimulus source answers with a word for that channel. The channel address moves through a one-conversion pipeline. An address given at one start does not steer the conversion that start opens. It only takes effect once that conversion ends, when the input goes back to sampling. Every result carries the channel it came from, so the pipeline can be seen at the ports.

Top module: `conv_sequencer`

## Requirements
- R1: After a synchronous reset, busy is 0, the sampled channel is 0, and the result data and result channel tag are both 0.
- R2: A start is taken when cs_n and conv_n are both low at a clock edge while the block is idle. busy reads 1 in the cycle after that edge.
- R3: The divider code sets the ratio of external clocks per internal clock: code 00 gives 1, 01 gives 2, 10 gives 4 and 11 gives 8. busy stays high for exactly 17 internal clocks, which is 17 x ratio external cycles.
- R4: 3 acquisition internal clocks follow each busy fall, so one full cycle is 20 internal clocks. A start is taken at the edge that ends acquisition, which is exactly 20 x ratio cycles after the previous start. A start seen earlier inside acquisition is ignored: busy stays 0 and the ignored address never enters the channel pipeline.
- R5: A start request while busy is high is ignored. The conversion length and the channel pipeline are unaffected.
- R6: result_data and result_chan change only at the edge where busy falls. They stay constant through conversion, acquisition and idle time.
- R7: The result holds the value sample_word had at the accepting start edge. It is tagged with the channel that was being sampled at that edge. Changes to sample_word during the conversion have no effect.
- R8: The channel address is captured at the first edge after an accepted start at which cs_n or conv_n is high, i.e. after a strobe rises. sample_chan takes that address at the end of the same conversion, so the address steers the following conversion.
- R9: The divider code is captured at the accepted start. Changing div_sel during a conversion does not alter that conversion's length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | External clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low chip select |
| conv_n | input | 1 | Active-low convert strobe |
| chan_addr | input | 2 | Mux channel address for the next-but-one conversion |
| div_sel | input | 2 | Clock ratio code (00:1, 01:2, 10:4, 11:8) |
| sample_word | input | 16 | Stimulus word for the channel on sample_chan |
| busy | output | 1 | High while a conversion runs |
| sample_chan | output | 2 | Channel the input mux is currently sampling |
| result_data | output | 16 | Latched conversion result |
| result_chan | output | 2 | Channel the latched result was sampled from |

## Verification
The bench runs every ratio code and counts busy-high cycles. An off-by-one in the tick counter or in the conversion counter would show up as a count other than 17 x ratio. Back-to-back starts placed exactly on the acquisition boundary catch a design that needs an extra idle cycle. A start placed early in acquisition catches one that reopens too soon. Starts injected mid-conversion, together with changes to div_sel and sample_word at the same moment, expose a design that restarts, retimes or resamples. A design that skipped the one-conversion address delay, or tagged results with the newly given address, would produce wrong result_chan tags from the second conversion onward.

// File: rtl/convseq_pkg.sv
package convseq_pkg;

    localparam int DATA_W      = 16;
    localparam int CHAN_W      = 2;
    localparam int DIVSEL_W    = 2;
    localparam int DIVCNT_W    = (1 << DIVSEL_W) - 1;  // enough bits for ratio-1 up to 7
    localparam int CONV_TICKS  = 17;
    localparam int ACQ_TICKS   = 3;
    localparam int PHASE_CNT_W = $clog2(CONV_TICKS + 1);

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_CONV = 2'd1,
        PH_ACQ  = 2'd2
    } phase_e;

    typedef struct packed {
        logic [CHAN_W-1:0] chan;
        logic [DATA_W-1:0] data;
    } sample_t;

    // last count value of the tick divider for a given ratio code
    function automatic logic [DIVCNT_W-1:0] div_limit(input logic [DIVSEL_W-1:0] code);
        return DIVCNT_W'((1 << code) - 1);
    endfunction

endpackage

// File: rtl/convseq_clkdiv.sv
module convseq_clkdiv
    import convseq_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                restart,
    input  logic [DIVSEL_W-1:0] ratio_code,
    output logic                tick
);

    logic [DIVCNT_W-1:0] cnt_q;
    logic [DIVCNT_W-1:0] lim;

    assign lim  = div_limit(ratio_code);
    assign tick = (cnt_q == lim);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt_q <= '0;
        end else if (cnt_q == lim) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_DIV_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= lim);  // R3

    AST_DIV_TICK_SPACING: assert property (@(posedge clk) disable iff (rst)
        (tick && (lim != '0) && !restart) |=> !tick);  // R3

endmodule

// File: rtl/convseq_ctrl.sv
module convseq_ctrl
    import convseq_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                cs_n,
    input  logic                conv_n,
    input  logic [DIVSEL_W-1:0] div_sel,
    input  logic                tick,
    output logic                busy,
    output logic                accept,
    output logic                eoc,
    output logic [DIVSEL_W-1:0] div_q
);

    localparam logic [PHASE_CNT_W-1:0] CONV_LAST = PHASE_CNT_W'(CONV_TICKS - 1);
    localparam logic [PHASE_CNT_W-1:0] ACQ_LAST  = PHASE_CNT_W'(ACQ_TICKS - 1);

    phase_e                 phase_q;
    logic [PHASE_CNT_W-1:0] tcnt_q;
    logic                   start_req;
    logic                   acq_end;

    assign start_req = !cs_n && !conv_n;
    assign acq_end   = (phase_q == PH_ACQ) && tick && (tcnt_q == ACQ_LAST);
    assign eoc       = (phase_q == PH_CONV) && tick && (tcnt_q == CONV_LAST);
    assign accept    = start_req && ((phase_q == PH_IDLE) || acq_end);
    assign busy      = (phase_q == PH_CONV);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            tcnt_q  <= '0;
            div_q   <= '0;
        end else if (accept) begin
            phase_q <= PH_CONV;
            tcnt_q  <= '0;
            div_q   <= div_sel;
        end else begin
            unique case (phase_q)
                PH_CONV: if (tick) begin
                    if (tcnt_q == CONV_LAST) begin
                        phase_q <= PH_ACQ;
                        tcnt_q  <= '0;
                    end else begin
                        tcnt_q <= tcnt_q + 1'b1;
                    end
                end
                PH_ACQ: if (tick) begin
                    if (tcnt_q == ACQ_LAST) begin
                        phase_q <= PH_IDLE;
                        tcnt_q  <= '0;
                    end else begin
                        tcnt_q <= tcnt_q + 1'b1;
                    end
                end
                default: tcnt_q <= '0;
            endcase
        end
    end

    AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (rst)
        accept |=> busy);  // R2

    AST_BUSY_NEEDS_START: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start_req));  // R2

    AST_BUSY_HELD: assert property (@(posedge clk) disable iff (rst)
        (busy && !eoc) |=> busy);  // R5

    AST_EOC_TO_ACQ: assert property (@(posedge clk) disable iff (rst)
        eoc |=> (phase_q == PH_ACQ) && !busy);  // R4

    AST_DIV_HOLD: assert property (@(posedge clk) disable iff (rst)
        ((phase_q != PH_IDLE) && !accept) |=> $stable(div_q));  // R9

endmodule

// File: rtl/convseq_chan_pipe.sv
module convseq_chan_pipe
    import convseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              conv_n,
    input  logic [CHAN_W-1:0] chan_addr,
    input  logic              accept,
    input  logic              eoc,
    output logic [CHAN_W-1:0] sample_chan
);

    logic              armed_q;
    logic [CHAN_W-1:0] addr_q;
    logic [CHAN_W-1:0] sample_chan_q;
    logic              strobe_rise;

    // a strobe going high after an accepted start closes the address window
    assign strobe_rise = armed_q && (cs_n || conv_n);
    assign sample_chan = sample_chan_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q       <= 1'b0;
            addr_q        <= '0;
            sample_chan_q <= '0;
        end else begin
            if (accept) begin
                armed_q <= 1'b1;
            end else if (strobe_rise || eoc) begin
                armed_q <= 1'b0;
            end
            if (strobe_rise) begin
                addr_q <= chan_addr;
            end
            if (eoc) begin
                sample_chan_q <= armed_q ? chan_addr : addr_q;
            end
        end
    end

    AST_SAMPLE_CHAN_HOLD: assert property (@(posedge clk) disable iff (rst)
        !eoc |=> $stable(sample_chan_q));  // R8

    AST_ARM_ON_START: assert property (@(posedge clk) disable iff (rst)
        accept |=> armed_q);  // R8

endmodule

// File: rtl/convseq_result.sv
module convseq_result
    import convseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic              eoc,
    input  logic [DATA_W-1:0] sample_word,
    input  logic [CHAN_W-1:0] sample_chan,
    output sample_t           result
);

    sample_t hold_q;
    sample_t res_q;

    assign result = res_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
            res_q  <= '0;
        end else begin
            if (accept) begin
                hold_q.chan <= sample_chan;
                hold_q.data <= sample_word;
            end
            if (eoc) begin
                res_q <= hold_q;
            end
        end
    end

    AST_RESULT_STABLE: assert property (@(posedge clk) disable iff (rst)
        !eoc |=> $stable(res_q));  // R6

    AST_RESULT_FROM_HOLD: assert property (@(posedge clk) disable iff (rst)
        eoc |=> (res_q == $past(hold_q)));  // R7

endmodule

// File: rtl/conv_sequencer.sv
module conv_sequencer
    import convseq_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                cs_n,
    input  logic                conv_n,
    input  logic [CHAN_W-1:0]   chan_addr,
    input  logic [DIVSEL_W-1:0] div_sel,
    input  logic [DATA_W-1:0]   sample_word,
    output logic                busy,
    output logic [CHAN_W-1:0]   sample_chan,
    output logic [DATA_W-1:0]   result_data,
    output logic [CHAN_W-1:0]   result_chan
);

    logic                tick;
    logic                accept;
    logic                eoc;
    logic [DIVSEL_W-1:0] div_q;
    sample_t             result;

    convseq_clkdiv u_div (
        .clk        (clk),
        .rst        (rst),
        .restart    (accept),
        .ratio_code (div_q),
        .tick       (tick)
    );

    convseq_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .cs_n    (cs_n),
        .conv_n  (conv_n),
        .div_sel (div_sel),
        .tick    (tick),
        .busy    (busy),
        .accept  (accept),
        .eoc     (eoc),
        .div_q   (div_q)
    );

    convseq_chan_pipe u_chan (
        .clk         (clk),
        .rst         (rst),
        .cs_n        (cs_n),
        .conv_n      (conv_n),
        .chan_addr   (chan_addr),
        .accept      (accept),
        .eoc         (eoc),
        .sample_chan (sample_chan)
    );

    convseq_result u_res (
        .clk         (clk),
        .rst         (rst),
        .accept      (accept),
        .eoc         (eoc),
        .sample_word (sample_word),
        .sample_chan (sample_chan),
        .result      (result)
    );

    assign result_data = result.data;
    assign result_chan = result.chan;

endmodule

// File: tb/conv_sequencer_tb.sv
module conv_sequencer_tb_top;

    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs_n = 1'b1;
    logic        conv_n = 1'b1;
    logic [1:0]  chan_addr = 2'd0;
    logic [1:0]  div_sel = 2'd0;
    logic [13:0] stim_base = 14'd0;
    logic [15:0] sample_word;
    logic        busy;
    logic [1:0]  sample_chan;
    logic [15:0] result_data;
    logic [1:0]  result_chan;

    int checks = 0;
    int fails = 0;
    int model_chan = 0;

    // stimulus: the "analog" word depends on the channel being sampled
    assign sample_word = {stim_base, sample_chan};

    always #(CLK_PERIOD / 2) clk = ~clk;

    conv_sequencer dut_i (
        .clk         (clk),
        .rst         (rst),
        .cs_n        (cs_n),
        .conv_n      (conv_n),
        .chan_addr   (chan_addr),
        .div_sel     (div_sel),
        .sample_word (sample_word),
        .busy        (busy),
        .sample_chan (sample_chan),
        .result_data (result_data),
        .result_chan (result_chan)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_chan = 0;
        chk(busy == 1'b0, "R1", "busy after reset", busy, 0);
        chk(sample_chan == 2'd0, "R1", "sample_chan after reset", sample_chan, 0);
        chk(result_data == 16'd0, "R1", "result_data after reset", result_data, 0);
        chk(result_chan == 2'd0, "R1", "result_chan after reset", result_chan, 0);
    endtask

    // one conversion; inject>0 places a start request (plus div/stimulus change)
    // at that busy-high cycle; acq_wait = posedges waited after busy falls
    task automatic run_conv(input logic [1:0] addr, input logic [1:0] div,
                            input logic [13:0] base, input int inject, input int acq_wait);
        int r = 1 << div;
        int n;
        bit stable_ok = 1'b1;
        logic [15:0] prev_data = result_data;
        logic [1:0]  prev_chan = result_chan;
        logic [1:0]  tag_exp = 2'(model_chan);
        @(negedge clk);
        div_sel = div; stim_base = base;
        cs_n = 1'b0; conv_n = 1'b0; chan_addr = addr;
        @(negedge clk);
        cs_n = 1'b1; conv_n = 1'b1;
        chk(busy == 1'b1, "R2", "busy one cycle after start", busy, 1);
        n = 1;
        forever begin
            if (inject > 0 && n == inject) begin
                cs_n = 1'b0; conv_n = 1'b0; chan_addr = ~addr;
                div_sel = ~div; stim_base = ~base;
            end else if (inject > 0 && n == inject + 1) begin
                cs_n = 1'b1; conv_n = 1'b1; chan_addr = addr;
            end
            if (result_data != prev_data || result_chan != prev_chan) stable_ok = 1'b0;
            @(negedge clk);
            if (!busy) break;
            n++;
            if (n > 400) break;
        end
        cs_n = 1'b1; conv_n = 1'b1; chan_addr = addr;
        div_sel = div; stim_base = base;
        chk(stable_ok, "R6", "result stable while busy", int'(stable_ok), 1);
        chk(n == 17 * r, "R3", "busy length in cycles", n, 17 * r);
        chk(result_data == {base, tag_exp}, "R7", "result_data", result_data, int'({base, tag_exp}));
        chk(result_chan == tag_exp, "R7", "result_chan tag", result_chan, tag_exp);
        chk(sample_chan == addr, "R8", "sample_chan after end", sample_chan, addr);
        model_chan = addr;
        repeat (acq_wait) @(posedge clk);
    endtask

    task automatic t_ratios();
        run_conv(2'd1, 2'd0, 14'h0123, 0, 3);
        run_conv(2'd2, 2'd1, 14'h02A5, 0, 6);
        run_conv(2'd3, 2'd2, 14'h1C3F, 0, 12);
        run_conv(2'd0, 2'd3, 14'h3001, 0, 24);
    endtask

    // R5 and R9: start, ratio change and stimulus change during busy
    task automatic t_busy_ignore();
        run_conv(2'd2, 2'd1, 14'h0F0F, 5, 6);
        run_conv(2'd1, 2'd2, 14'h2222, 30, 12);
    endtask

    // R4: next start lands exactly on the acquisition boundary
    task automatic t_back_to_back();
        run_conv(2'd3, 2'd0, 14'h0AAA, 0, 2);
        run_conv(2'd0, 2'd0, 14'h0555, 0, 5);
        run_conv(2'd2, 2'd1, 14'h1111, 0, 5);
        run_conv(2'd1, 2'd1, 14'h0777, 0, 6);
    endtask

    // R4: a start inside the acquisition window is ignored
    task automatic t_acq_ignore();
        logic [15:0] d_prev;
        logic [1:0]  c_prev;
        run_conv(2'd2, 2'd1, 14'h1234, 0, 0);
        d_prev = result_data;
        c_prev = result_chan;
        cs_n = 1'b0; conv_n = 1'b0; chan_addr = 2'd3;
        @(negedge clk);
        cs_n = 1'b1; conv_n = 1'b1; chan_addr = 2'd0;
        chk(busy == 1'b0, "R4", "busy after start in acquisition", busy, 0);
        @(negedge clk);
        chk(busy == 1'b0, "R4", "busy stays low in acquisition", busy, 0);
        chk(sample_chan == 2'd2, "R4", "sample_chan unchanged by ignored start", sample_chan, 2);
        chk(result_data == d_prev && result_chan == c_prev, "R6",
            "result unchanged in acquisition", result_data, d_prev);
        repeat (8) @(posedge clk);
        // channel 2 must be sampled next, not the ignored address 3
        run_conv(2'd0, 2'd0, 14'h0321, 0, 3);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_ratios();
        t_busy_ignore();
        t_back_to_back();
        t_acq_ignore();
        repeat (4) @(posedge clk);
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

endmodule